// File: doc/BRIEF.md
# Row Tag Metadata Buffer for a DRAM Cache

This block sits in front of a large DRAM cache whose rows carry their own metadata: every DRAM row holds a few cache blocks of 128 bytes each, plus a tag field for every one of those blocks. Reading those tags from DRAM on every lookup would double the DRAM traffic. The block keeps the complete tag group of recently used rows in a small direct-mapped on-chip array, so most lookups resolve without touching DRAM metadata.

A lookup gives a DRAM row, a block slot within that row and the slow-memory tag being looked for. If the row's tag group is held on chip, the block hit or miss is reported in the very next cycle, and a hit is followed by a single data command to DRAM. If the row is not held, the block evicts the slot's previous occupant and writes that occupant's metadata back to its own row first when it was modified on chip. It then reads the requested row's metadata, installs it and finishes the lookup. Because the metadata read has just opened that row, the follow-up data command finds the row already open. One lookup is handled at a time.

Top module: `row_tag_buffer`

## Requirements
- R1: After reset `reqReady` is 1, `resValid` and `dramCmdValid` are 0, and every slot is empty, so the first lookup of any row is reported with `resBufHit` = 0.
- R2: The buffer has 64 slots and is direct-mapped. The slot is chosen by the low 6 bits of `reqRow`, and the remaining upper row bits are kept as the slot's row tag. A lookup of one slot leaves the contents of every other slot unchanged.
- R3: On a lookup whose row is not buffered and whose slot holds no modified metadata, exactly one command of kind 0 (metadata read) is issued for `reqRow`. The answer on `dramRspMeta` is installed, and the result then carries `resBufHit` = 0.
- R4: The metadata word is 40 bits. Block slot i uses bits [10*i+9 : 10*i], with the block tag in its low 8 bits, the dirty flag in bit 8 and the valid flag in bit 9.
- R5: When the row is buffered, `resValid` rises in the cycle right after the request is accepted, with `resBufHit` = 1, and no metadata command is issued.
- R6: `resHit` is 1 only when the block slot's valid flag is set and its stored tag equals `reqTag`. A read (op 0) or write (op 1) that hits issues exactly one data command for that row and block: kind 2 (data read) for op 0, kind 3 (data write) for op 1. A block miss issues no data command.
- R7: A write (op 1) that hits sets the block's dirty flag. A fill (op 2) stores `reqTag` in the block with valid set and dirty clear, and always issues one kind 3 data command. Both of these mark the slot as modified on chip.
- R8: When a lookup misses a slot that holds modified metadata, one kind 1 command (metadata write) is issued first. It goes to the victim's own row (its row tag joined to the slot index) and carries the victim's updated metadata. The kind 0 read for the new row follows it.
- R9: When a lookup misses a slot whose metadata was not modified since install, no metadata write is issued.
- R10: `reqReady` is 0 from the cycle after a request is accepted until its last DRAM command has been accepted.
- R11: While `dramCmdValid` is 1 and `dramCmdReady` is 0, the command kind, row, block and metadata are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block can accept a lookup |
| reqRow | input | 14 | DRAM row of the lookup |
| reqBlock | input | 2 | Block slot within the row |
| reqTag | input | 8 | Slow-memory tag being looked for |
| reqOp | input | 2 | 0 read, 1 write, 2 fill (3 acts as read) |
| resValid | output | 1 | Result strobe |
| resHit | output | 1 | Block was present with a matching tag |
| resBufHit | output | 1 | Row tags were already buffered on chip |
| dramCmdValid | output | 1 | DRAM command present |
| dramCmdReady | input | 1 | DRAM side accepts the command |
| dramCmdKind | output | 2 | 0 metadata read, 1 metadata write, 2 data read, 3 data write |
| dramCmdRow | output | 14 | Row addressed by the command |
| dramCmdBlock | output | 2 | Block slot for data commands |
| dramCmdMeta | output | 40 | Metadata written by a kind 1 command |
| dramRspValid | input | 1 | Metadata read answer present |
| dramRspMeta | input | 40 | Metadata read answer |

## Verification
On every cycle the assertions check several ordering rules. A request is never accepted while another is in flight. A held command does not change under backpressure. A metadata write-back is always followed by the metadata read. A buffered lookup never produces a metadata command, a block miss never produces a data command, and an install always makes the next comparison hit. The scenarios must show the rest. The bit layout of the written-back word is one part of that. So are the slot selection by low row bits, the difference between clean and modified evictions, and whether metadata changed on chip comes back intact from DRAM after an eviction. The cycle count to a buffered result also needs a scenario.

// File: rtl/row_tag_buf_pkg.sv
package row_tag_buf_pkg;

  typedef enum logic [1:0] {
    CMD_META_RD = 2'd0,
    CMD_META_WR = 2'd1,
    CMD_DATA_RD = 2'd2,
    CMD_DATA_WR = 2'd3
  } dram_cmd_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_FILL  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;
    logic applyUpdate;
    logic install;
  } strobes_t;

  // status from datapath to control
  typedef struct packed {
    logic entryHit;
    logic blkHit;
    logic victimDirty;
    logic isWrite;
    logic isFill;
  } status_t;

endpackage

// File: rtl/row_tag_buf_datapath.sv
module row_tag_buf_datapath
  import row_tag_buf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ROW_W   = 14,
  parameter int BLOCKS  = 4,
  parameter int TAG_W   = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int RTAG_W  = ROW_W - IDX_W,
  localparam int BLK_W   = $clog2(BLOCKS),
  localparam int FIELD_W = TAG_W + 2,
  localparam int META_W  = BLOCKS * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  dram_cmd_e         cmdKind,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [1:0]        reqOp,
  input  logic [META_W-1:0] rspMeta,
  output status_t           stat,
  output logic              fetched,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [BLK_W-1:0]  cmdBlock,
  output logic [META_W-1:0] cmdMeta
);

  logic [ROW_W-1:0] rowQ;
  logic [BLK_W-1:0] blkQ;
  logic [TAG_W-1:0] tagQ;
  logic [1:0]       opQ;
  logic             fetchedQ;

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entModified;
  logic [RTAG_W-1:0]  entRowTag [ENTRIES];
  logic [META_W-1:0]  entMeta   [ENTRIES];

  logic [IDX_W-1:0]   idx;
  logic [RTAG_W-1:0]  rowTagReq;
  logic [META_W-1:0]  curMeta;
  logic [FIELD_W-1:0] curField;
  logic [META_W-1:0]  updMeta;
  logic               updMod;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      blkQ     <= '0;
      tagQ     <= '0;
      opQ      <= OP_READ;
      fetchedQ <= 1'b0;
    end else if (strb.capReq) begin
      rowQ     <= reqRow;
      blkQ     <= reqBlock;
      tagQ     <= reqTag;
      opQ      <= reqOp;
      fetchedQ <= 1'b0;
    end else if (strb.install) begin
      fetchedQ <= 1'b1;
    end
  end

  assign idx       = rowQ[IDX_W-1:0];
  assign rowTagReq = rowQ[ROW_W-1:IDX_W];
  assign curMeta   = entMeta[idx];
  assign curField  = curMeta[blkQ*FIELD_W +: FIELD_W];

  assign stat.entryHit    = entValid[idx] && (entRowTag[idx] == rowTagReq);
  assign stat.blkHit      = curField[FIELD_W-1] && (curField[TAG_W-1:0] == tagQ);
  assign stat.victimDirty = entValid[idx] && entModified[idx];
  assign stat.isWrite     = (opQ == OP_WRITE);
  assign stat.isFill      = (opQ == OP_FILL);
  assign fetched          = fetchedQ;

  // metadata change made by the current lookup
  always_comb begin
    updMeta = curMeta;
    updMod  = 1'b0;
    if (opQ == OP_FILL) begin
      updMeta[blkQ*FIELD_W +: FIELD_W] = {1'b1, 1'b0, tagQ};
      updMod = 1'b1;
    end else if (opQ == OP_WRITE && stat.blkHit) begin
      updMeta[blkQ*FIELD_W + TAG_W] = 1'b1;
      updMod = 1'b1;
    end
  end

  // slot state flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid    <= '0;
      entModified <= '0;
    end else if (strb.install) begin
      entValid[idx]    <= 1'b1;
      entModified[idx] <= 1'b0;
    end else if (strb.applyUpdate && updMod) begin
      entModified[idx] <= 1'b1;
    end
  end

  // slot contents
  always_ff @(posedge clk) begin
    if (strb.install) begin
      entRowTag[idx] <= rowTagReq;
      entMeta[idx]   <= rspMeta;
    end else if (strb.applyUpdate) begin
      entMeta[idx]   <= updMeta;
    end
  end

  assign cmdRow   = (cmdKind == CMD_META_WR) ? {entRowTag[idx], idx} : rowQ;
  assign cmdBlock = blkQ;
  assign cmdMeta  = curMeta;

  // R2: an installed group is found by the comparison in the next cycle
  a_r2_install_hits: assert property (@(posedge clk) disable iff (!rstN)
    strb.install |=> stat.entryHit);

endmodule

// File: rtl/row_tag_buf_ctrl.sv
module row_tag_buf_ctrl
  import row_tag_buf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      resValid,
  input  status_t   stat,
  output strobes_t  strb,
  output logic      cmdValid,
  input  logic      cmdReady,
  output dram_cmd_e cmdKind,
  input  logic      rspValid
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WBACK, S_FETCH, S_WAIT, S_DATA
  } state_e;

  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt      = st;
    strb     = '0;
    reqReady = 1'b0;
    resValid = 1'b0;
    cmdValid = 1'b0;
    cmdKind  = CMD_META_RD;
    case (st)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capReq = 1'b1;
          nxt = S_LOOK;
        end
      end
      S_LOOK: begin
        if (stat.entryHit) begin
          resValid         = 1'b1;
          strb.applyUpdate = 1'b1;
          nxt = (stat.blkHit || stat.isFill) ? S_DATA : S_IDLE;
        end else begin
          nxt = stat.victimDirty ? S_WBACK : S_FETCH;
        end
      end
      S_WBACK: begin
        cmdValid = 1'b1;
        cmdKind  = CMD_META_WR;
        if (cmdReady) nxt = S_FETCH;
      end
      S_FETCH: begin
        cmdValid = 1'b1;
        cmdKind  = CMD_META_RD;
        if (cmdReady) nxt = S_WAIT;
      end
      S_WAIT: begin
        if (rspValid) begin
          strb.install = 1'b1;
          nxt = S_LOOK;
        end
      end
      S_DATA: begin
        cmdValid = 1'b1;
        cmdKind  = (stat.isWrite || stat.isFill) ? CMD_DATA_WR : CMD_DATA_RD;
        if (cmdReady) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R10: a second request is never taken while one is in flight
  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R11: a held command does not change
  a_r11_cmd_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdKind)));

  // R8: a metadata write-back is followed by the metadata read
  a_r8_fetch_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdKind == CMD_META_WR) |=>
      (cmdValid && cmdKind == CMD_META_RD));

  // R5: a buffered result is never followed by a metadata command
  a_r5_no_meta_after_result: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !(cmdValid && (cmdKind == CMD_META_RD || cmdKind == CMD_META_WR)));

  // R6: a block miss that is not a fill issues no data command
  a_r6_no_data_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !stat.blkHit && !stat.isFill) |=> !cmdValid);

endmodule

// File: rtl/row_tag_buffer.sv
module row_tag_buffer
  import row_tag_buf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ROW_W   = 14,
  parameter int BLOCKS  = 4,
  parameter int TAG_W   = 8,
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int META_W = BLOCKS * (TAG_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [1:0]        reqOp,
  output logic              resValid,
  output logic              resHit,
  output logic              resBufHit,
  output logic              dramCmdValid,
  input  logic              dramCmdReady,
  output logic [1:0]        dramCmdKind,
  output logic [ROW_W-1:0]  dramCmdRow,
  output logic [BLK_W-1:0]  dramCmdBlock,
  output logic [META_W-1:0] dramCmdMeta,
  input  logic              dramRspValid,
  input  logic [META_W-1:0] dramRspMeta
);

  strobes_t  strb;
  status_t   stat;
  dram_cmd_e cmdKind;
  logic      fetched;

  row_tag_buf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .resValid (resValid),
    .stat     (stat),
    .strb     (strb),
    .cmdValid (dramCmdValid),
    .cmdReady (dramCmdReady),
    .cmdKind  (cmdKind),
    .rspValid (dramRspValid)
  );

  row_tag_buf_datapath #(
    .ENTRIES (ENTRIES),
    .ROW_W   (ROW_W),
    .BLOCKS  (BLOCKS),
    .TAG_W   (TAG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdKind  (cmdKind),
    .reqRow   (reqRow),
    .reqBlock (reqBlock),
    .reqTag   (reqTag),
    .reqOp    (reqOp),
    .rspMeta  (dramRspMeta),
    .stat     (stat),
    .fetched  (fetched),
    .cmdRow   (dramCmdRow),
    .cmdBlock (dramCmdBlock),
    .cmdMeta  (dramCmdMeta)
  );

  assign dramCmdKind = cmdKind;
  assign resHit      = stat.blkHit;
  assign resBufHit   = !fetched;

endmodule

// File: tb/row_tag_buffer_bench.sv
`timescale 1ns/1ps
module row_tag_buffer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [13:0] reqRow = '0;
  logic [1:0]  reqBlock = '0;
  logic [7:0]  reqTag = '0;
  logic [1:0]  reqOp = '0;
  logic        resValid, resHit, resBufHit;
  logic        dramCmdValid;
  logic        dramCmdReady = 1'b1;
  logic [1:0]  dramCmdKind;
  logic [13:0] dramCmdRow;
  logic [1:0]  dramCmdBlock;
  logic [39:0] dramCmdMeta;
  logic        dramRspValid;
  logic [39:0] dramRspMeta;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  row_tag_buffer u_row_tag_buffer (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow),
    .reqBlock(reqBlock), .reqTag(reqTag), .reqOp(reqOp),
    .resValid(resValid), .resHit(resHit), .resBufHit(resBufHit),
    .dramCmdValid(dramCmdValid), .dramCmdReady(dramCmdReady),
    .dramCmdKind(dramCmdKind), .dramCmdRow(dramCmdRow),
    .dramCmdBlock(dramCmdBlock), .dramCmdMeta(dramCmdMeta),
    .dramRspValid(dramRspValid), .dramRspMeta(dramRspMeta)
  );

  always #2 clk = ~clk;

  // DRAM model: metadata store, command log, read answer one cycle later
  logic [39:0] metaMem [16384];
  int          kindCnt [4];
  logic [1:0]  kindLog [8];
  int          logIdx = 0;
  logic [13:0] lastRow [4];
  logic [1:0]  lastBlk;
  logic [39:0] lastMeta;
  bit          readyToggle = 1'b0;

  initial begin
    for (int i = 0; i < 16384; i++) metaMem[i] = '0;
    for (int k = 0; k < 4; k++) begin kindCnt[k] = 0; lastRow[k] = '0; end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      dramRspValid <= 1'b0;
      dramRspMeta  <= '0;
    end else begin
      dramRspValid <= 1'b0;
      if (dramCmdValid && dramCmdReady) begin
        kindCnt[dramCmdKind] = kindCnt[dramCmdKind] + 1;
        if (logIdx < 8) kindLog[logIdx] = dramCmdKind;
        logIdx = logIdx + 1;
        lastRow[dramCmdKind] = dramCmdRow;
        if (dramCmdKind == 2'd0) begin
          dramRspValid <= 1'b1;
          dramRspMeta  <= metaMem[dramCmdRow];
        end else if (dramCmdKind == 2'd1) begin
          metaMem[dramCmdRow] = dramCmdMeta;
          lastMeta = dramCmdMeta;
        end else begin
          lastBlk = dramCmdBlock;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (readyToggle) dramCmdReady <= ~dramCmdReady;
    else             dramCmdReady <= 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected under 20000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [9:0] fld(logic v, logic d, logic [7:0] t);
    return {v, d, t};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  int snap [4];
  task automatic mark();
    for (int k = 0; k < 4; k++) snap[k] = kindCnt[k];
    logIdx = 0;
  endtask

  // issue one lookup; returns result fields and cycles to result
  task automatic lookup(input logic [13:0] row, input logic [1:0] blk,
                        input logic [7:0] tag, input logic [1:0] op,
                        output logic bufHit, output logic hit, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqRow = row; reqBlock = blk; reqTag = tag; reqOp = op;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 reqReady low after accept", reqReady, 0);
    lat = 1;
    while (!resValid && lat < 60) begin @(negedge clk); lat++; end
    bufHit = resBufHit;
    hit    = resHit;
    for (int w = 0; w < 60 && !reqReady; w++) @(negedge clk);
    chk("R10 reqReady back when done", reqReady, 1);
  endtask

  task automatic t_reset();
    chk("R1 reqReady after reset", reqReady, 1);
    chk("R1 resValid after reset", resValid, 0);
    chk("R1 dramCmdValid after reset", dramCmdValid, 0);
  endtask

  task automatic t_cold_miss();
    logic b, h; int lat;
    metaMem[5] = {fld(0,0,8'h00), fld(0,0,8'h00), fld(1,0,8'h3C), fld(0,0,8'h00)};
    mark();
    lookup(14'd5, 2'd1, 8'h3C, 2'd0, b, h, lat);
    chk("R1 first lookup not buffered", b, 0);
    chk("R3 one metadata read", kindCnt[0] - snap[0], 1);
    chk("R3 metadata read row", lastRow[0], 5);
    chk("R9 no write-back on empty slot", kindCnt[1] - snap[1], 0);
    chk("R4 block 1 field decoded as hit", h, 1);
    chk("R6 one data read", kindCnt[2] - snap[2], 1);
    chk("R6 data row and block", {lastRow[2], lastBlk}, {14'd5, 2'd1});
  endtask

  task automatic t_buf_hit_paths();
    logic b, h; int lat;
    mark();
    lookup(14'd5, 2'd2, 8'h11, 2'd0, b, h, lat);
    chk("R5 buffered flag", b, 1);
    chk("R5 result one cycle after accept", lat, 1);
    chk("R6 invalid block misses", h, 0);
    chk("R5 no metadata commands", (kindCnt[0] - snap[0]) + (kindCnt[1] - snap[1]), 0);
    chk("R6 no data command on miss", (kindCnt[2] - snap[2]) + (kindCnt[3] - snap[3]), 0);
    mark();
    lookup(14'd5, 2'd1, 8'h3D, 2'd0, b, h, lat);
    chk("R6 tag mismatch misses", h, 0);
    chk("R6 no data command on mismatch", kindCnt[2] - snap[2], 0);
  endtask

  task automatic t_fill_write();
    logic b, h; int lat;
    mark();
    lookup(14'd5, 2'd2, 8'h22, 2'd2, b, h, lat);
    chk("R7 fill reports prior miss", h, 0);
    chk("R7 fill issues one data write", kindCnt[3] - snap[3], 1);
    mark();
    lookup(14'd5, 2'd2, 8'h22, 2'd0, b, h, lat);
    chk("R7 filled block hits", {b, h}, 2'b11);
    mark();
    lookup(14'd5, 2'd1, 8'h3C, 2'd1, b, h, lat);
    chk("R6 write hit", h, 1);
    chk("R6 write hit issues data write", kindCnt[3] - snap[3], 1);
  endtask

  task automatic t_dirty_evict();
    logic b, h; int lat;
    metaMem[69] = {fld(0,0,0), fld(0,0,0), fld(0,0,0), fld(1,0,8'h44)};
    mark();
    readyToggle = 1'b1;
    lookup(14'd69, 2'd0, 8'h44, 2'd0, b, h, lat);
    readyToggle = 1'b0;
    chk("R8 one write-back", kindCnt[1] - snap[1], 1);
    chk("R8 write-back row of victim", lastRow[1], 5);
    chk("R8 write-back content", lastMeta,
        {fld(0,0,0), fld(1,0,8'h22), fld(1,1,8'h3C), fld(0,0,0)});
    chk("R8 write-back before read", {kindLog[0], kindLog[1]}, {2'd1, 2'd0});
    chk("R11 commands counted once under backpressure", kindCnt[0] - snap[0], 1);
    chk("R2 conflicting row refetched", {b, h}, 2'b01);
  endtask

  task automatic t_clean_evict_and_index();
    logic b, h; int lat;
    mark();
    readyToggle = 1'b1;
    lookup(14'd133, 2'd0, 8'h00, 2'd0, b, h, lat);
    readyToggle = 1'b0;
    chk("R9 clean victim no write-back", kindCnt[1] - snap[1], 0);
    chk("R3 read of new row", lastRow[0], 133);
    lookup(14'd6, 2'd0, 8'h00, 2'd0, b, h, lat);
    chk("R2 other slot not buffered", b, 0);
    mark();
    lookup(14'd133, 2'd3, 8'h00, 2'd0, b, h, lat);
    chk("R2 slot 5 kept while slot 6 loaded", b, 1);
    chk("R2 no metadata command", kindCnt[0] - snap[0], 0);
    lookup(14'd5, 2'd1, 8'h3C, 2'd0, b, h, lat);
    chk("R8 written-back metadata reloads", {b, h}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_buf_hit_paths();
    t_fill_write();
    t_dirty_evict();
    t_clean_evict_and_index();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule